// File: doc/BRIEF.md
# Vertical Key-Tap Substitution Stage

This stage sits in front of one three-tap vertical filter in a display scaler. Each clock it receives a top, a center and a bottom pixel. Each pixel carries an RGB value and a flag that is set when the pixel matches the color key. Taps that match the key are swapped for a nearby non-key pixel before the filter blends them. This stops a key color that contrasts with the surrounding image from smearing into the blended result.

When the rules decide that no blending may happen, the stage raises a bypass flag and supplies one pixel to pass on directly. An output key flag tells the horizontal stage whether that bypass pixel must stay a key pixel. The `CENTER_BANK` parameter chooses the rule set. The middle filter of a bank protects its center tap. The outer filters fill in from the nearest clean neighbour.

Internally the stage sorts the key-flag pattern into one named substitution case. The cases are `SUB_PASS`, `SUB_FIX_TOP`, `SUB_FIX_BOT`, `SUB_FIX_CTR`, `SUB_FIX_EDGES`, `SUB_KEEP_ONE` and `SUB_KEEP_KEY`. A source select names which tap a bypass case keeps. The selector turns the case into tap values, and one register stage holds all outputs. There is no state between cycles: every cycle is classified afresh.

Top module: `vkey_tap_sub`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.
- R3: With `keep_en` low, the three taps leave unchanged, and `byp_vld` and `out_key` are 0, whatever the key flags.
- R4: Outer bank, only the top tap keyed: `tap_top` takes the center pixel. The other taps are unchanged.
- R5: Outer bank, only the bottom tap keyed: `tap_bot` takes the center pixel. The other taps are unchanged.
- R6: Outer bank, only the center tap keyed: `tap_ctr` takes the top pixel. The other taps are unchanged.
- R7: Outer bank, exactly two taps keyed: `byp_vld` is 1, `out_key` is 0, and `byp_px` and all three taps equal the one unkeyed pixel.
- R8: Outer bank, all three taps keyed: `byp_vld` and `out_key` are 1, and `byp_px` and all three taps equal the bottom pixel. `out_key` is never 1 without `byp_vld`.
- R9: Center bank, center not keyed: a keyed top tap and a keyed bottom tap are each replaced by the center pixel on their own. The bypass stays off.
- R10: Center bank, center keyed: `byp_vld` and `out_key` are 1, and `byp_px` and all three taps equal the center pixel, whatever the other flags.
- R11: With `keep_en` high and no tap keyed, the taps leave unchanged and `byp_vld` is 0.
- R12: Whenever `byp_vld` is 0, `byp_px` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| keep_en | input | 1 | Enables key-preserving substitution |
| top_px | input | 3*CW | Top tap RGB |
| ctr_px | input | 3*CW | Center tap RGB |
| bot_px | input | 3*CW | Bottom tap RGB |
| top_key | input | 1 | Top tap matches the key |
| ctr_key | input | 1 | Center tap matches the key |
| bot_key | input | 1 | Bottom tap matches the key |
| tap_top | output | 3*CW | Substituted top tap |
| tap_ctr | output | 3*CW | Substituted center tap |
| tap_bot | output | 3*CW | Substituted bottom tap |
| byp_vld | output | 1 | Filter must be bypassed with `byp_px` |
| byp_px | output | 3*CW | Pixel to pass on directly |
| out_key | output | 1 | Passed-on pixel is a key pixel |

## Verification
The bench builds two copies of the stage, both with `CW` = 2, so each pixel is 6 bits wide. Instance `u0` uses `CENTER_BANK` = 0 and instance `u1` uses `CENTER_BANK` = 1. With both rule sets present, every one of the eight key-flag patterns, with the enable at both levels, is applied to each bank. Eight distinct pixel triples are applied per pattern, so each substitution source can be told apart from its neighbours.

// File: rtl/vkey_pkg.sv
package vkey_pkg;

    typedef enum logic [2:0] {
        SUB_PASS,
        SUB_FIX_TOP,
        SUB_FIX_BOT,
        SUB_FIX_CTR,
        SUB_FIX_EDGES,
        SUB_KEEP_ONE,
        SUB_KEEP_KEY
    } sub_case_e;

    typedef enum logic [1:0] {
        SRC_TOP,
        SRC_CTR,
        SRC_BOT
    } src_e;

endpackage

// File: rtl/vkey_classify.sv
module vkey_classify
    import vkey_pkg::*;
#(
    parameter bit CENTER_BANK = 1'b0
) (
    input  logic      en,
    input  logic      kt,
    input  logic      kc,
    input  logic      kb,
    output sub_case_e cs,
    output src_e      src
);

    generate
        if (CENTER_BANK) begin : g_center
            always_comb begin
                src = SRC_CTR;
                cs  = SUB_PASS;
                if (en) begin
                    if (kc) begin
                        cs = SUB_KEEP_KEY;
                    end else begin
                        unique case ({kt, kb})
                            2'b00: cs = SUB_PASS;
                            2'b10: cs = SUB_FIX_TOP;
                            2'b01: cs = SUB_FIX_BOT;
                            2'b11: cs = SUB_FIX_EDGES;
                            default: cs = SUB_PASS;
                        endcase
                    end
                end
            end
        end else begin : g_outer
            always_comb begin
                src = SRC_BOT;
                cs  = SUB_PASS;
                if (en) begin
                    unique case ({kt, kc, kb})
                        3'b000: cs = SUB_PASS;
                        3'b100: cs = SUB_FIX_TOP;
                        3'b001: cs = SUB_FIX_BOT;
                        3'b010: cs = SUB_FIX_CTR;
                        3'b110: begin cs = SUB_KEEP_ONE; src = SRC_BOT; end
                        3'b011: begin cs = SUB_KEEP_ONE; src = SRC_TOP; end
                        3'b101: begin cs = SUB_KEEP_ONE; src = SRC_CTR; end
                        3'b111: begin cs = SUB_KEEP_KEY; src = SRC_BOT; end
                        default: cs = SUB_PASS;
                    endcase
                end
            end
        end
    endgenerate

endmodule

// File: rtl/vkey_select.sv
module vkey_select
    import vkey_pkg::*;
#(
    parameter int PW = 24
) (
    input  sub_case_e       cs,
    input  src_e            src,
    input  logic [PW-1:0]   top,
    input  logic [PW-1:0]   ctr,
    input  logic [PW-1:0]   bot,
    output logic [PW-1:0]   nt,
    output logic [PW-1:0]   nc,
    output logic [PW-1:0]   nb,
    output logic            bv,
    output logic [PW-1:0]   bp,
    output logic            bk
);

    logic [PW-1:0] kept;

    always_comb begin
        unique case (src)
            SRC_TOP: kept = top;
            SRC_CTR: kept = ctr;
            SRC_BOT: kept = bot;
            default: kept = bot;
        endcase
    end

    always_comb begin
        nt = top;
        nc = ctr;
        nb = bot;
        bv = 1'b0;
        bp = '0;
        bk = 1'b0;
        unique case (cs)
            SUB_PASS:      ;
            SUB_FIX_TOP:   nt = ctr;
            SUB_FIX_BOT:   nb = ctr;
            SUB_FIX_CTR:   nc = top;
            SUB_FIX_EDGES: begin nt = ctr; nb = ctr; end
            SUB_KEEP_ONE: begin
                nt = kept; nc = kept; nb = kept;
                bv = 1'b1; bp = kept;
            end
            SUB_KEEP_KEY: begin
                nt = kept; nc = kept; nb = kept;
                bv = 1'b1; bp = kept; bk = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vkey_tap_sub.sv
module vkey_tap_sub
    import vkey_pkg::*;
#(
    parameter int CW          = 8,
    parameter bit CENTER_BANK = 1'b0,
    localparam int PW         = 3 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          keep_en,
    input  logic [PW-1:0] top_px,
    input  logic [PW-1:0] ctr_px,
    input  logic [PW-1:0] bot_px,
    input  logic          top_key,
    input  logic          ctr_key,
    input  logic          bot_key,
    output logic [PW-1:0] tap_top,
    output logic [PW-1:0] tap_ctr,
    output logic [PW-1:0] tap_bot,
    output logic          byp_vld,
    output logic [PW-1:0] byp_px,
    output logic          out_key
);

    sub_case_e     cs;
    src_e          src;
    logic [PW-1:0] nt, nc, nb, bp;
    logic          bv, bk;

    vkey_classify #(.CENTER_BANK(CENTER_BANK)) u_cls (
        .en  (keep_en),
        .kt  (top_key),
        .kc  (ctr_key),
        .kb  (bot_key),
        .cs  (cs),
        .src (src)
    );

    vkey_select #(.PW(PW)) u_sel (
        .cs  (cs),
        .src (src),
        .top (top_px),
        .ctr (ctr_px),
        .bot (bot_px),
        .nt  (nt),
        .nc  (nc),
        .nb  (nb),
        .bv  (bv),
        .bp  (bp),
        .bk  (bk)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_top <= '0;
            tap_ctr <= '0;
            tap_bot <= '0;
            byp_vld <= 1'b0;
            byp_px  <= '0;
            out_key <= 1'b0;
        end else begin
            tap_top <= nt;
            tap_ctr <= nc;
            tap_bot <= nb;
            byp_vld <= bv;
            byp_px  <= bp;
            out_key <= bk;
        end
    end

endmodule

// File: rtl/vkey_tap_sub_chk.sv
module vkey_tap_sub_chk #(
    parameter int CW          = 8,
    parameter bit CENTER_BANK = 1'b0,
    localparam int PW         = 3 * CW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          keep_en,
    input logic [PW-1:0] top_px,
    input logic [PW-1:0] ctr_px,
    input logic [PW-1:0] bot_px,
    input logic          top_key,
    input logic          ctr_key,
    input logic          bot_key,
    input logic [PW-1:0] tap_top,
    input logic [PW-1:0] tap_ctr,
    input logic [PW-1:0] tap_bot,
    input logic          byp_vld,
    input logic [PW-1:0] byp_px,
    input logic          out_key
);

    assert_bypass_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !byp_vld |-> byp_px == '0);

    assert_key_needs_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_key |-> byp_vld);

    assert_disabled_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(keep_en)) |->
        (tap_top == $past(top_px) && tap_ctr == $past(ctr_px) &&
         tap_bot == $past(bot_px) && !byp_vld && !out_key));

    generate
        if (CENTER_BANK) begin : g_center
            assert_center_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(keep_en) && $past(ctr_key)) |->
                (byp_vld && out_key && byp_px == $past(ctr_px)));
        end else begin : g_outer
            assert_all_key_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(keep_en) &&
                 $past(top_key && ctr_key && bot_key)) |->
                (out_key && byp_px == $past(bot_px)));
            assert_two_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(keep_en) &&
                 $past($countones({top_key, ctr_key, bot_key}) == 2)) |->
                (byp_vld && !out_key));
        end
    endgenerate

endmodule

bind vkey_tap_sub vkey_tap_sub_chk #(.CW(CW), .CENTER_BANK(CENTER_BANK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .keep_en (keep_en),
    .top_px  (top_px),
    .ctr_px  (ctr_px),
    .bot_px  (bot_px),
    .top_key (top_key),
    .ctr_key (ctr_key),
    .bot_key (bot_key),
    .tap_top (tap_top),
    .tap_ctr (tap_ctr),
    .tap_bot (tap_bot),
    .byp_vld (byp_vld),
    .byp_px  (byp_px),
    .out_key (out_key)
);

// File: tb/sim_vkey_tap_sub.sv
`timescale 1ns/1ps
module sim_vkey_tap_sub;

    localparam int CW = 2;
    localparam int PW = 3 * CW;
    localparam int OW = 4 * PW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          keep_en = 1'b0;
    logic [PW-1:0] top_px = '0, ctr_px = '0, bot_px = '0;
    logic          top_key = 1'b0, ctr_key = 1'b0, bot_key = 1'b0;

    logic [PW-1:0] o_t, o_c, o_b, o_bp, c_t, c_c, c_b, c_bp;
    logic          o_bv, o_k, c_bv, c_k;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    vkey_tap_sub #(.CW(CW), .CENTER_BANK(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .keep_en(keep_en),
        .top_px(top_px), .ctr_px(ctr_px), .bot_px(bot_px),
        .top_key(top_key), .ctr_key(ctr_key), .bot_key(bot_key),
        .tap_top(o_t), .tap_ctr(o_c), .tap_bot(o_b),
        .byp_vld(o_bv), .byp_px(o_bp), .out_key(o_k));

    vkey_tap_sub #(.CW(CW), .CENTER_BANK(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .keep_en(keep_en),
        .top_px(top_px), .ctr_px(ctr_px), .bot_px(bot_px),
        .top_key(top_key), .ctr_key(ctr_key), .bot_key(bot_key),
        .tap_top(c_t), .tap_ctr(c_c), .tap_bot(c_b),
        .byp_vld(c_bv), .byp_px(c_bp), .out_key(c_k));

    task automatic check(input string req, input logic [OW-1:0] got, input logic [OW-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [OW-1:0] model(input bit center, input bit en,
        input bit kt, input bit kc, input bit kb,
        input logic [PW-1:0] t, input logic [PW-1:0] c, input logic [PW-1:0] b);
        logic [PW-1:0] nt, nc, nb, bp;
        bit v, k;
        int nk;
        nt = t; nc = c; nb = b; bp = '0; v = 0; k = 0;
        nk = int'(kt) + int'(kc) + int'(kb);
        if (en) begin
            if (center) begin
                if (kc) begin
                    nt = c; nc = c; nb = c; bp = c; v = 1; k = 1;
                end else begin
                    if (kt) nt = c;
                    if (kb) nb = c;
                end
            end else if (nk == 1) begin
                if (kt) nt = c;
                else if (kb) nb = c;
                else nc = t;
            end else if (nk == 2) begin
                bp = !kt ? t : (!kc ? c : b);
                nt = bp; nc = bp; nb = bp; v = 1;
            end else if (nk == 3) begin
                bp = b; nt = b; nc = b; nb = b; v = 1; k = 1;
            end
        end
        return {nt, nc, nb, v, bp, k};
    endfunction

    function automatic string tag(input bit center, input bit en,
        input bit kt, input bit kc, input bit kb);
        int nk;
        nk = int'(kt) + int'(kc) + int'(kb);
        if (!en) return "R3";
        if (nk == 0) return "R11";
        if (center) return kc ? "R10" : "R9";
        if (nk == 3) return "R8";
        if (nk == 2) return "R7";
        if (kt) return "R4";
        if (kb) return "R5";
        return "R6";
    endfunction

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [OW-1:0] eo, ec;
        // R1: reset clears everything even with active inputs
        keep_en = 1'b1; top_px = 6'h15; ctr_px = 6'h2a; bot_px = 6'h3f;
        top_key = 1'b1; ctr_key = 1'b1; bot_key = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 outer", {o_t, o_c, o_b, o_bv, o_bp, o_k}, '0);
        check("R1 center", {c_t, c_c, c_b, c_bv, c_bp, c_k}, '0);
        rst_n = 1'b1;
        // R2: no change before the edge, result after exactly one edge
        keep_en = 1'b0;
        #1;
        check("R2 before edge", {o_t, o_c, o_b, o_bv, o_bp, o_k}, '0);
        @(posedge clk);
        @(negedge clk);
        check("R2 after edge", {o_t, o_c, o_b, o_bv, o_bp, o_k},
              model(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'h15, 6'h2a, 6'h3f));
        for (int en = 0; en < 2; en++) begin
            for (int f = 0; f < 8; f++) begin
                for (int p = 0; p < 8; p++) begin
                    keep_en = en[0];
                    top_key = f[2]; ctr_key = f[1]; bot_key = f[0];
                    top_px = PW'(p * 5 + 1);
                    ctr_px = PW'(p * 7 + 34);
                    bot_px = PW'(p * 11 + 19);
                    eo = model(1'b0, en[0], f[2], f[1], f[0], top_px, ctr_px, bot_px);
                    ec = model(1'b1, en[0], f[2], f[1], f[0], top_px, ctr_px, bot_px);
                    @(posedge clk);
                    @(negedge clk);
                    check({tag(1'b0, en[0], f[2], f[1], f[0]), " outer R12"},
                          {o_t, o_c, o_b, o_bv, o_bp, o_k}, eo);
                    check({tag(1'b1, en[0], f[2], f[1], f[0]), " center R12"},
                          {c_t, c_c, c_b, c_bv, c_bp, c_k}, ec);
                end
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule